// File: doc/BRIEF.md
# Low-Power CPU Clock and Sleep-State Controller

This block sits beside the CPU of a small microcontroller and decides when the core gets a clock and which always-on helpers stay powered. While running, it turns the oscillator clock into a CPU clock enable at a rate set by a software divider. Software can rewrite the divider at any moment. A new value is only picked up at the end of the current CPU clock period, so no period is ever cut short.

Software asks for sleep with a one-cycle `sleep_go` strobe. `sleep_deep` chooses between plain power-down and total power-down. In either sleep state the main oscillator is stopped. The watchdog and the real-time timer keep running. The brownout detector and comparators stay up only in plain power-down. The RC oscillator is kept alive only when it is both the system clock and feeding an enabled real-time timer.

An enabled interrupt (`wake_irq`) starts the main oscillator again at once. The CPU clock stays gated until a start-up counter has run out. Any reset also ends sleep. The controller's own sequencing clock is modelled as always present; in silicon it would come from an always-on source.

Top module: `lpclk_ctrl`

## Requirements
- R1: While `rst_n` is low, `osc_en`, `bod_en` and `wdt_en` are 1.
- R2: In the run state, `cpu_clk_en` pulses once every cycle when the divider value N is 0, and once every 2×N cycles when N is nonzero. N is 8 bits wide, so the largest period is 510 cycles.
- R3: A divider value written in the middle of a period leaves that period at its old length. The new value governs the periods that start after the next `cpu_clk_en` pulse, and two pulses are never back to back while N is nonzero.
- R4: In the run state, a `sleep_go` pulse enters power-down (`sleep_deep`=0) or total power-down (`sleep_deep`=1) on the next clock edge. `osc_en` and `cpu_clk_en` then read 0. `sleep_go` is ignored while asleep or starting up.
- R5: In power-down, `bod_en`=1, `cmp_en`=`cfg_cmp_en`, `wdt_en`=1 and `rtc_en`=`cfg_rtc_en`.
- R6: In total power-down, `bod_en`=0 and `cmp_en`=0. `wdt_en` and `rtc_en` behave as in R5.
- R7: In either sleep state, `rc_en` = `cfg_rc_sysclk` AND `cfg_rtc_en`. Outside sleep, `rc_en` = `cfg_rc_sysclk`.
- R8: `wake_irq` in a sleep state raises `osc_en` on the next edge. `cpu_clk_en` then stays 0 for STARTUP_CYC cycles before running resumes. `wake_irq` has no effect in the run state.
- R9: Asserting `rst_n` low during any sleep state returns the block to the run state immediately.
- R10: In the run state, `bod_en`=1 and `cmp_en`=`cfg_cmp_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock / sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset, any source |
| div_val | input | 8 | Divider value N (0 = undivided, else 2×N) |
| sleep_go | input | 1 | One-cycle sleep request strobe |
| sleep_deep | input | 1 | Selects total power-down with `sleep_go` |
| wake_irq | input | 1 | Enabled interrupt wake request |
| cfg_rc_sysclk | input | 1 | RC oscillator is the system clock |
| cfg_rtc_en | input | 1 | Real-time timer enabled |
| cfg_cmp_en | input | 1 | Comparators enabled by software |
| cpu_clk_en | output | 1 | CPU clock enable pulse |
| osc_en | output | 1 | Main oscillator enable |
| rc_en | output | 1 | RC oscillator enable |
| bod_en | output | 1 | Brownout detector enable |
| cmp_en | output | 1 | Comparator enable |
| wdt_en | output | 1 | Watchdog enable |
| rtc_en | output | 1 | Real-time timer enable |

## Verification
The assertions watch several rules on every cycle. The latched divider period may change only at a CPU clock pulse or while the clock is gated. A pulse is never followed at once by another while a nonzero divider is pending. The oscillator never comes up together with a CPU pulse. Sleep entry drops the oscillator, and deep entry also drops the brownout detector and comparators. The RC oscillator stays on during sleep only under the joint condition. The exact pulse spacing for each divider value, the preserved length of a period interrupted by a rewrite, and the length of the start-up gate can only be shown by the bench's timed scenarios. The same goes for strobes and wakes being ignored in the wrong state.

// File: rtl/lpclk_pkg.sv
package lpclk_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PD   = 2'd1,
    ST_TPD  = 2'd2,
    ST_WARM = 2'd3
  } lp_state_t;
endpackage

// File: rtl/lpclk_div.sv
module lpclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  // terminal count of the period currently being timed
  assign term   = (per_q == '0) ? '0 : ({per_q, 1'b0} - CNT_W'(1));
  assign tick_o = run_i && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q <= '0;
      per_q <= div_i;   // new ratio only picked up at a period boundary
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3: the latched period only moves at a boundary or while gated
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != $past(per_q)) |-> $past(tick_o || !run_i));

  // R3: a nonzero pending ratio never yields two adjacent pulses
  p_no_back2back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i != '0) |=> !tick_o);
endmodule

// File: rtl/lpclk_seq.sv
module lpclk_seq
  import lpclk_pkg::*;
#(
  parameter int STARTUP_CYC = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_go,
  input  logic      sleep_deep,
  input  logic      wake_irq,
  output lp_state_t state_o
);
  localparam int WCNT_W = $clog2(STARTUP_CYC + 1);

  lp_state_t         state_q;
  logic [WCNT_W-1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      wcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_RUN: if (sleep_go) state_q <= sleep_deep ? ST_TPD : ST_PD;
        ST_PD, ST_TPD: if (wake_irq) begin
          state_q <= ST_WARM;
          wcnt_q  <= '0;
        end
        ST_WARM: begin
          if (wcnt_q == WCNT_W'(STARTUP_CYC - 1)) state_q <= ST_RUN;
          else wcnt_q <= wcnt_q + WCNT_W'(1);
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign state_o = state_q;

  // R4: a strobe in the run state always leaves the run state
  p_sleep_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_go) |=> (state_q != ST_RUN));

  // R8: sleep states only exit to the start-up state
  p_wake_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_PD || state_q == ST_TPD) && wake_irq) |=> (state_q == ST_WARM));
endmodule

// File: rtl/lpclk_en_dec.sv
module lpclk_en_dec
  import lpclk_pkg::*;
(
  input  lp_state_t state_i,
  input  logic      cfg_rc_sysclk,
  input  logic      cfg_rtc_en,
  input  logic      cfg_cmp_en,
  output logic      osc_en,
  output logic      rc_en,
  output logic      bod_en,
  output logic      cmp_en,
  output logic      wdt_en,
  output logic      rtc_en
);
  logic asleep, deep;

  assign asleep = (state_i == ST_PD) || (state_i == ST_TPD);
  assign deep   = (state_i == ST_TPD);

  always_comb begin
    osc_en = !asleep;
    rc_en  = asleep ? (cfg_rc_sysclk && cfg_rtc_en) : cfg_rc_sysclk;
    bod_en = !deep;
    cmp_en = cfg_cmp_en && !deep;
    wdt_en = 1'b1;
    rtc_en = cfg_rtc_en;
  end
endmodule

// File: rtl/lpclk_ctrl.sv
module lpclk_ctrl
  import lpclk_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int STARTUP_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             sleep_go,
  input  logic             sleep_deep,
  input  logic             wake_irq,
  input  logic             cfg_rc_sysclk,
  input  logic             cfg_rtc_en,
  input  logic             cfg_cmp_en,
  output logic             cpu_clk_en,
  output logic             osc_en,
  output logic             rc_en,
  output logic             bod_en,
  output logic             cmp_en,
  output logic             wdt_en,
  output logic             rtc_en
);
  lp_state_t state;
  logic      running;

  assign running = (state == ST_RUN);

  lpclk_seq #(.STARTUP_CYC(STARTUP_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .sleep_go(sleep_go), .sleep_deep(sleep_deep),
    .wake_irq(wake_irq), .state_o(state)
  );

  lpclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(running), .div_i(div_val), .tick_o(cpu_clk_en)
  );

  lpclk_en_dec u_dec (
    .state_i(state), .cfg_rc_sysclk(cfg_rc_sysclk), .cfg_rtc_en(cfg_rtc_en),
    .cfg_cmp_en(cfg_cmp_en), .osc_en(osc_en), .rc_en(rc_en), .bod_en(bod_en),
    .cmp_en(cmp_en), .wdt_en(wdt_en), .rtc_en(rtc_en)
  );

  // R4: accepted sleep strobe stops the oscillator and the CPU clock
  p_osc_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sleep_go) |=> (!osc_en && !cpu_clk_en));

  // R6: deep sleep drops brownout detector and comparators
  p_tpd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sleep_go && sleep_deep) |=> (!bod_en && !cmp_en));

  // R7: RC stays on during sleep only under the joint condition
  p_rc_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && rc_en) |-> (cfg_rc_sysclk && cfg_rtc_en));

  // R8: oscillator restart never coincides with a CPU pulse
  p_gated_warm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !cpu_clk_en);
endmodule

// File: tb/lpclk_ctrl_bench.sv
`timescale 1ns/1ps
module lpclk_ctrl_bench;
  localparam int S = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_val = '0;
  logic       sleep_go = 1'b0, sleep_deep = 1'b0, wake_irq = 1'b0;
  logic       cfg_rc_sysclk = 1'b0, cfg_rtc_en = 1'b0, cfg_cmp_en = 1'b0;
  logic       cpu_clk_en, osc_en, rc_en, bod_en, cmp_en, wdt_en, rtc_en;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  lpclk_ctrl #(.DIV_W(8), .STARTUP_CYC(S)) u_lpclk_ctrl (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .sleep_go(sleep_go),
    .sleep_deep(sleep_deep), .wake_irq(wake_irq), .cfg_rc_sysclk(cfg_rc_sysclk),
    .cfg_rtc_en(cfg_rtc_en), .cfg_cmp_en(cfg_cmp_en), .cpu_clk_en(cpu_clk_en),
    .osc_en(osc_en), .rc_en(rc_en), .bod_en(bod_en), .cmp_en(cmp_en),
    .wdt_en(wdt_en), .rtc_en(rtc_en)
  );

  // {divider value, expected pulse spacing in cycles}
  localparam int VEC[5][2] = '{'{0, 1}, '{1, 2}, '{3, 6}, '{255, 510}, '{2, 4}};

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (cpu_clk_en) return;
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      n++;
      if (cpu_clk_en) return;
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 bod_en", bod_en, 1);
    chk("R1 wdt_en", wdt_en, 1);
    rst_n = 1'b1;

    // R2 vector walk
    for (int v = 0; v < 5; v++) begin
      @(negedge clk);
      div_val = 8'(VEC[v][0]);
      wait_pulse();
      gap(n);
      chk($sformatf("R2 spacing N=%0d", VEC[v][0]), n, VEC[v][1]);
    end

    // R3 rewrite mid-period keeps current period
    @(negedge clk);
    div_val = 8'd4;
    wait_pulse();
    @(negedge clk); @(negedge clk);
    div_val = 8'd1;
    gap(n);
    chk("R3 interrupted period", n + 2, 8);
    gap(n);
    chk("R3 new period", n, 2);

    // R10 run enables, R8 wake ignored while running
    @(negedge clk);
    div_val = 8'd0;
    cfg_cmp_en = 1'b1; cfg_rc_sysclk = 1'b1; cfg_rtc_en = 1'b0;
    wake_irq = 1'b1;
    @(negedge clk);
    wake_irq = 1'b0;
    chk("R10 cmp_en run", cmp_en, 1);
    chk("R10 bod_en run", bod_en, 1);
    chk("R7 rc_en run", rc_en, 1);
    wait_pulse();
    gap(n);
    chk("R8 wake ignored in run", n, 1);
    chk("R8 osc stays on", osc_en, 1);

    // R4/R5 power-down
    cfg_rtc_en = 1'b1;
    sleep_go = 1'b1; sleep_deep = 1'b0;
    @(negedge clk);
    sleep_go = 1'b0;
    chk("R4 osc_en pd", osc_en, 0);
    chk("R4 cpu_clk_en pd", cpu_clk_en, 0);
    chk("R5 bod_en pd", bod_en, 1);
    chk("R5 cmp_en pd", cmp_en, 1);
    chk("R5 wdt_en pd", wdt_en, 1);
    chk("R5 rtc_en pd", rtc_en, 1);
    chk("R7 rc_en pd joint", rc_en, 1);
    cfg_rtc_en = 1'b0;
    @(negedge clk);
    chk("R7 rc_en pd no rtc", rc_en, 0);
    chk("R5 rtc_en follows cfg", rtc_en, 0);
    sleep_go = 1'b1;
    @(negedge clk);
    sleep_go = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 strobe ignored asleep", osc_en, 0);
    chk("R4 cpu gated asleep", cpu_clk_en, 0);

    // R8 wake with start-up gate; R4 strobe ignored during start-up
    wake_irq = 1'b1;
    for (int i = 1; i <= S; i++) begin
      @(negedge clk);
      wake_irq = 1'b0;
      sleep_go = (i == 3);
      chk($sformatf("R8 osc_en warm %0d", i), osc_en, 1);
      chk($sformatf("R8 cpu gated warm %0d", i), cpu_clk_en, 0);
    end
    sleep_go = 1'b0;
    @(negedge clk);
    chk("R8 cpu resumes", cpu_clk_en, 1);
    chk("R4 strobe ignored in start-up", osc_en, 1);

    // R6 total power-down
    cfg_rtc_en = 1'b1; cfg_cmp_en = 1'b1; cfg_rc_sysclk = 1'b1;
    sleep_go = 1'b1; sleep_deep = 1'b1;
    @(negedge clk);
    sleep_go = 1'b0; sleep_deep = 1'b0;
    chk("R6 bod_en tpd", bod_en, 0);
    chk("R6 cmp_en tpd", cmp_en, 0);
    chk("R6 wdt_en tpd", wdt_en, 1);
    chk("R6 rtc_en tpd", rtc_en, 1);
    chk("R6 osc_en tpd", osc_en, 0);
    chk("R7 rc_en tpd joint", rc_en, 1);
    cfg_rc_sysclk = 1'b0;
    @(negedge clk);
    chk("R7 rc_en tpd not sysclk", rc_en, 0);

    // R9 reset exits sleep
    rst_n = 1'b0;
    #1;
    chk("R9 osc_en on reset", osc_en, 1);
    chk("R9 bod_en on reset", bod_en, 1);
    @(negedge clk);
    rst_n = 1'b1;
    wait_pulse();
    gap(n);
    chk("R9 run after reset", n, 1);

    finish_up();
  end
endmodule